// File: doc/BRIEF.md
# Byte-Stuffed Frame Encapsulator

This block turns a stream of payload bytes into framed, byte-stuffed traffic for a serial transmitter's FIFO. Every frame is wrapped in a start-of-text byte (0x02) at each end, and any payload byte that could be mistaken for a delimiter or for the escape code is sent with a data-link-escape byte (0x10) in front of it. The receiving side can then find frame edges without knowing the frame length in advance.

The FIFO is filled in bursts rather than one byte at a time. A burst starts only when the FIFO reports that it is completely empty and a payload beat is waiting. Within a burst the block counts the FIFO slots it has used, and it stops taking payload while two slots remain. One is kept for a possible escape byte and one for the closing delimiter. A frame longer than one burst stays open and continues in the next burst without a second opening delimiter. At the end of each burst the block reports how many payload bytes it took. A busy level covers the whole burst so that a power controller can hold off sleep.

The payload side is a valid/ready stream. Each beat carries a byte, a last-of-frame marker, and a null marker. A beat with the null marker carries no byte and only closes the frame, so an empty frame is sent as a single null last beat.

Top module: `stx_frame_encoder`

## Requirements
- R1: When a burst starts with no frame open, the first FIFO write of the burst is 0x02, and the frame is then marked open.
- R2: A payload byte equal to 0x02 or 0x10 is written as 0x10 followed by the byte itself. Every other byte is written alone.
- R3: A burst begins only in a cycle where `fifoEmpty` is high and a payload beat is offered. `burstBusy` rises in the cycle after that condition.
- R4: Within a burst, a payload beat is accepted (`inReady` high) only while fewer than FIFO_DEPTH-2 (62) slots have been written. A burst never writes more than FIFO_DEPTH (64) entries.
- R5: After the last payload byte of a frame (including its escape, if any), the next write is a closing 0x02, and the frame is marked closed.
- R6: If the slot limit ends a burst before the frame's last byte, the next burst starts directly with payload, with no opening 0x02.
- R7: One cycle after a burst ends, `burstDone` pulses for one cycle, and `burstCount` equals the number of payload bytes taken in that burst. Delimiters and escape bytes are not counted.
- R8: `burstBusy` is high from the cycle after a burst starts through the cycle of its final FIFO write. Every `fifoWrEn` pulse occurs while `burstBusy` is high.
- R9: A null beat with the last marker closes the frame without writing a payload byte. A frame that consists only of such a beat produces exactly 0x02, 0x02.
- R10: After reset, `burstBusy`, `fifoWrEn`, `inReady` and `burstDone` are low, and no frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Payload beat offered |
| inData | input | 8 | Payload byte |
| inLast | input | 1 | Beat ends the frame |
| inNull | input | 1 | Beat carries no byte (used only together with inLast) |
| inReady | output | 1 | Beat accepted in this cycle when inValid is high |
| fifoEmpty | input | 1 | Transmit FIFO holds no entries |
| fifoWrEn | output | 1 | FIFO write strobe |
| fifoWrData | output | 8 | Byte written to the FIFO |
| burstBusy | output | 1 | A burst is in progress |
| burstDone | output | 1 | One-cycle pulse after a burst ends |
| burstCount | output | 7 | Payload bytes taken in the burst just ended |

## Verification
The assertions assume that `fifoEmpty` truly reflects an empty FIFO. They also assume that the FIFO is not written by anyone else during a burst, so the internal slot count matches its occupancy. A null beat is assumed to always carry the last marker, and an offered beat is assumed to stay stable until it is accepted. The bench meets these assumptions in three ways. It models a 64-entry FIFO that only this block writes and that drains at a fixed slow rate. It builds every frame from beats that are held until the handshake completes. It emits null beats only as the sole, final beat of an empty frame.

// File: rtl/stx_enc_pkg.sv
package stx_enc_pkg;

  localparam logic [7:0] SYM_STX = 8'h02;
  localparam logic [7:0] SYM_DLE = 8'h10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_DATA,
    ST_ESC,
    ST_CLOSE,
    ST_END
  } encState_t;

  // Strobes from control to datapath, at most one write strobe per cycle.
  typedef struct packed {
    logic startBurst;
    logic wrStx;
    logic wrEsc;
    logic wrIn;
    logic wrHeld;
    logic endBurst;
  } encStrobe_t;

endpackage

// File: rtl/stx_enc_ctrl.sv
module stx_enc_ctrl
  import stx_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inLast,
  input  logic       inNull,
  input  logic       isSpecial,
  input  logic       fifoEmpty,
  input  logic       slotsFull,
  output encStrobe_t strobe,
  output logic       inReady,
  output logic       busy,
  output logic       frameOpen
);

  encState_t state, nextState;
  logic      heldLast;

  always_comb begin
    strobe    = '0;
    inReady   = 1'b0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (inValid && fifoEmpty) begin
          strobe.startBurst = 1'b1;
          nextState = frameOpen ? ST_DATA : ST_OPEN;
        end
      end
      ST_OPEN: begin
        strobe.wrStx = 1'b1;
        nextState    = ST_DATA;
      end
      ST_DATA: begin
        if (slotsFull) begin
          nextState = ST_END;
        end else begin
          inReady = 1'b1;
          if (inValid) begin
            if (inNull) begin
              nextState = ST_CLOSE;
            end else if (isSpecial) begin
              strobe.wrEsc = 1'b1;
              nextState    = ST_ESC;
            end else begin
              strobe.wrIn = 1'b1;
              nextState   = inLast ? ST_CLOSE : ST_DATA;
            end
          end
        end
      end
      ST_ESC: begin
        strobe.wrHeld = 1'b1;
        nextState     = heldLast ? ST_CLOSE : ST_DATA;
      end
      ST_CLOSE: begin
        strobe.wrStx = 1'b1;
        nextState    = ST_END;
      end
      ST_END: begin
        strobe.endBurst = 1'b1;
        nextState       = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      frameOpen <= 1'b0;
      heldLast  <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_OPEN)  frameOpen <= 1'b1;
      if (state == ST_CLOSE) frameOpen <= 1'b0;
      if (strobe.wrEsc)      heldLast  <= inLast;
    end
  end

  assign busy = (state != ST_IDLE);

  // A burst may only have been launched out of an empty FIFO.
  assert_start_on_empty_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(fifoEmpty));

  // Resumed bursts never reopen: opening only happens from a closed frame.
  assert_open_once_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameOpen) |-> $past(state == ST_OPEN) && !$past(frameOpen));

endmodule

// File: rtl/stx_enc_datapath.sv
module stx_enc_datapath
  import stx_enc_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int HEADROOM   = 2,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       inData,
  input  encStrobe_t       strobe,
  output logic             isSpecial,
  output logic             slotsFull,
  output logic             fifoWrEn,
  output logic [7:0]       fifoWrData,
  output logic [CNT_W-1:0] burstCount,
  output logic             burstDone
);

  localparam int SLOT_LIMIT = FIFO_DEPTH - HEADROOM;

  logic [CNT_W-1:0] slotsUsed;
  logic [CNT_W-1:0] payCount;
  logic [7:0]       heldByte;
  logic             escIssued;
  logic             anyWrite;
  logic [7:0]       wrByte;

  assign isSpecial = (inData == SYM_STX) || (inData == SYM_DLE);
  assign slotsFull = (slotsUsed >= CNT_W'(SLOT_LIMIT));
  assign anyWrite  = strobe.wrStx | strobe.wrEsc | strobe.wrIn | strobe.wrHeld;

  always_comb begin
    wrByte = inData;
    if (strobe.wrStx)       wrByte = SYM_STX;
    else if (strobe.wrEsc)  wrByte = SYM_DLE;
    else if (strobe.wrHeld) wrByte = heldByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotsUsed  <= '0;
      payCount   <= '0;
      heldByte   <= '0;
      escIssued  <= 1'b0;
      fifoWrEn   <= 1'b0;
      fifoWrData <= '0;
      burstCount <= '0;
      burstDone  <= 1'b0;
    end else begin
      if (strobe.startBurst)  slotsUsed <= '0;
      else if (anyWrite)      slotsUsed <= slotsUsed + 1'b1;
      if (strobe.startBurst)                 payCount <= '0;
      else if (strobe.wrIn || strobe.wrHeld) payCount <= payCount + 1'b1;
      if (strobe.wrEsc)    heldByte   <= inData;
      if (strobe.endBurst) burstCount <= payCount;
      escIssued  <= strobe.wrEsc;
      fifoWrEn   <= anyWrite;
      fifoWrData <= wrByte;
      burstDone  <= strobe.endBurst;
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    slotsUsed <= CNT_W'(FIFO_DEPTH));

  // An escape write is always followed at once by a delimiter-valued byte.
  assert_escape_pair_R2: assert property (@(posedge clk) disable iff (!rstN)
    escIssued |=> fifoWrEn && (fifoWrData == SYM_STX || fifoWrData == SYM_DLE));

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |-> burstCount <= CNT_W'(SLOT_LIMIT));

endmodule

// File: rtl/stx_frame_encoder.sv
module stx_frame_encoder
  import stx_enc_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  parameter int HEADROOM   = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               inValid,
  input  logic [7:0]                         inData,
  input  logic                               inLast,
  input  logic                               inNull,
  output logic                               inReady,
  input  logic                               fifoEmpty,
  output logic                               fifoWrEn,
  output logic [7:0]                         fifoWrData,
  output logic                               burstBusy,
  output logic                               burstDone,
  output logic [$clog2(FIFO_DEPTH+1)-1:0]    burstCount
);

  encStrobe_t strobe;
  logic       isSpecial;
  logic       slotsFull;
  logic       frameOpen;

  stx_enc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inLast    (inLast),
    .inNull    (inNull),
    .isSpecial (isSpecial),
    .fifoEmpty (fifoEmpty),
    .slotsFull (slotsFull),
    .strobe    (strobe),
    .inReady   (inReady),
    .busy      (burstBusy),
    .frameOpen (frameOpen)
  );

  stx_enc_datapath #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .HEADROOM   (HEADROOM)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .inData     (inData),
    .strobe     (strobe),
    .isSpecial  (isSpecial),
    .slotsFull  (slotsFull),
    .fifoWrEn   (fifoWrEn),
    .fifoWrData (fifoWrData),
    .burstCount (burstCount),
    .burstDone  (burstDone)
  );

  assert_close_delim_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameOpen) |-> fifoWrEn && fifoWrData == SYM_STX);

  assert_write_in_burst_R8: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> burstBusy);

endmodule

// File: tb/stx_frame_encoder_tb.sv
module stx_frame_encoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int LIMIT      = DEPTH - 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inData = '0;
  logic       inLast = 1'b0;
  logic       inNull = 1'b0;
  logic       inReady;
  logic       fifoEmpty;
  logic       fifoWrEn;
  logic [7:0] fifoWrData;
  logic       burstBusy;
  logic       burstDone;
  logic [6:0] burstCount;

  int vectors = 0;
  int errors  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stx_frame_encoder u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inLast(inLast), .inNull(inNull), .inReady(inReady),
    .fifoEmpty(fifoEmpty), .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData),
    .burstBusy(burstBusy), .burstDone(burstDone), .burstCount(burstCount)
  );

  // Model of the transmit FIFO: one entry leaves every fourth cycle.
  int fifoOcc = 0;
  int maxOcc  = 0;
  int drainDiv = 0;
  assign fifoEmpty = (fifoOcc == 0);

  always @(posedge clk) begin
    if (!rstN) begin
      fifoOcc  <= 0;
      drainDiv <= 0;
    end else begin
      drainDiv <= (drainDiv + 1) % 4;
      fifoOcc  <= fifoOcc + (fifoWrEn ? 1 : 0) - ((drainDiv == 3 && fifoOcc != 0) ? 1 : 0);
    end
  end

  // Scoreboard queues.
  logic [7:0] expQ[$];
  string      tagQ[$];
  int         cntQ[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Requirement-level model of burst slicing.
  bit mOpen = 0, mInBurst = 0, mResumed = 0;
  int mUsed = 0, mCount = 0;

  task automatic push_exp(input logic [7:0] b, input string tag);
    expQ.push_back(b);
    tagQ.push_back(tag);
  endtask

  task automatic model_beat(input logic [7:0] d, input bit last, input bit nul);
    if (!mInBurst) begin
      mInBurst = 1; mUsed = 0; mCount = 0; mResumed = mOpen;
      if (!mOpen) begin
        push_exp(8'h02, "R1"); mUsed = 1; mOpen = 1;
      end
    end
    if (!nul) begin
      if (d == 8'h02 || d == 8'h10) begin
        push_exp(8'h10, "R2"); push_exp(d, "R2"); mUsed += 2;
      end else begin
        push_exp(d, mResumed ? "R6" : "R2"); mUsed += 1;
      end
      mResumed = 0;
      mCount++;
    end
    if (last) begin
      push_exp(8'h02, nul ? "R9" : "R5");
      mOpen = 0; mInBurst = 0; cntQ.push_back(mCount);
    end else if (mUsed >= LIMIT) begin
      mInBurst = 0; cntQ.push_back(mCount);
    end
  endtask

  int beatNo = 0;
  task automatic send_beat(input logic [7:0] d, input bit last, input bit nul);
    bit rdy;
    model_beat(d, last, nul);
    @(negedge clk);
    if (beatNo % 5 == 4) @(negedge clk);  // idle gap on the input
    beatNo++;
    inValid = 1; inData = d; inLast = last; inNull = nul;
    forever begin
      rdy = inReady;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
    @(negedge clk);
    inValid = 0; inLast = 0; inNull = 0;
  endtask

  function automatic logic [7:0] gen(input int kind, input int i);
    case (kind)
      0: gen = 8'h41 + i[7:0];
      1: gen = (i % 2) ? 8'h10 : 8'h02;
      2: gen = (i % 7 == 0) ? 8'h02 : ((i % 11 == 0) ? 8'h10 : (i[7:0] ^ 8'h5A) | 8'h20);
      3: gen = 8'h10;
      default: gen = 8'h60 + i[3:0];
    endcase
  endfunction

  task automatic send_frame(input int len, input int kind, input bit lastSpecial);
    if (len == 0) begin
      send_beat(8'h00, 1, 1);          // R9 empty frame
    end else begin
      for (int i = 0; i < len; i++) begin
        logic [7:0] b;
        b = (lastSpecial && i == len - 1) ? 8'h02 : gen(kind, i);
        send_beat(b, i == len - 1, 0);
      end
    end
  endtask

  // Monitors, sampling on the falling edge.
  bit prevBusy = 0, prevEmpty = 1;
  always @(negedge clk) begin
    if (rstN) begin
      if (fifoWrEn) begin
        if (expQ.size() == 0) begin
          check(0, "R2", fifoWrData, -1);
        end else begin
          logic [7:0] e; string t;
          e = expQ.pop_front(); t = tagQ.pop_front();
          check(fifoWrData == e, t, fifoWrData, e);
        end
        check(burstBusy, "R8", burstBusy, 1);
      end
      if (burstBusy && !prevBusy) check(prevEmpty, "R3", prevEmpty, 1);
      if (burstDone) begin
        if (cntQ.size() == 0) check(0, "R7", burstCount, -1);
        else begin
          int c; c = cntQ.pop_front();
          check(burstCount == c, "R7", burstCount, c);
        end
      end
      if (fifoOcc > maxOcc) maxOcc = fifoOcc;
      prevBusy  = burstBusy;
      prevEmpty = fifoEmpty;
    end
  end

  // Watchdog.
  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check(!burstBusy, "R10", burstBusy, 0);
    check(!fifoWrEn, "R10", fifoWrEn, 0);
    check(!inReady, "R10", inReady, 0);
    check(!burstDone, "R10", burstDone, 0);
    rstN = 1;
    send_frame(4, 0, 0);        // plain short frame
    send_frame(4, 1, 0);        // delimiter-valued payload, R2
    send_frame(0, 0, 0);        // empty frame, R9
    send_frame(150, 2, 0);      // spans bursts, R6
    send_frame(61, 0, 0);       // last byte at slot 62, R4 boundary
    send_frame(62, 0, 0);       // limit hits one byte early, R6
    send_frame(40, 3, 0);       // all escapes
    send_frame(61, 0, 1);       // escaped last byte fills all 64 slots, R4
    send_frame(0, 0, 0);
    repeat (400) @(negedge clk);
    check(expQ.size() == 0, "R5", expQ.size(), 0);
    check(cntQ.size() == 0, "R7", cntQ.size(), 0);
    check(maxOcc <= DEPTH, "R4", maxOcc, DEPTH);
    check(!burstBusy, "R8", burstBusy, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule